// File: doc/BRIEF.md
# Pipelined Shift-and-Add IQ Phase Rotator

This block turns a stream of complex baseband samples through a chosen angle. It never forms a complex exponential and never multiplies. Each sample enters a chain of registered micro-rotation stages. Every stage applies an arithmetic shift by a power of two, adds or subtracts, and updates a residual angle against a stored arctangent constant. A first registered stage swaps and negates I and Q to take care of whole quarter turns. After that step the remaining angle always lies inside the range the iterations can converge on.

The angle comes from a 32-bit phase word. This word is the sum of a running accumulator and a static offset. With a zero increment, the offset sets a fixed phase shift. With a nonzero increment, the accumulator steps once per accepted sample, and the block acts as a digital frequency shifter. The enable input advances the phase accumulator and every pipeline register together. One sample is accepted on each enabled clock.

The output amplitude carries the fixed iteration gain of about 1.6468. There is one extra integer bit of headroom for it. Gain correction is left to the logic that follows.

Top module: `iq_phase_rotator`

## Requirements
- R1: For an input (I, Q) and an angle code A, the rotation angle is 2π·A/2^ZW, where A is an unsigned ZW-bit code. The outputs equal K·(I·cosθ − Q·sinθ) and K·(I·sinθ + Q·cosθ) to within ±3 LSB. K is the product of sqrt(1+2^(−2i)) for i = 0 to STAGES−1, about 1.6468. The outputs are DW+1-bit two's complement.
- R2: The phase word is the accumulator plus the offset, modulo 2^32. A is bits [31:32−ZW] of this word. The accumulator is zero after reset. At every enabled clock it adds the increment, after the current sample has used the old value. The offset and the angle may change on every sample.
- R3: Every quadrant is handled, including angle codes at exactly 0°, 90°, 180° and −90° and codes just below a quadrant boundary. Top angle bits 01 swap to (−Q, I) and take a quarter turn off the angle. Bits 10 swap to (Q, −I) and add a quarter turn. After this step the residual lies within ±90°.
- R4: A sample accepted at an enabled clock edge appears on the outputs right after the STAGES-th later enabled edge. One new result is produced per enabled clock.
- R5: While the enable input is low, the data, angle and increment inputs are ignored. The outputs, the valid flag and the accumulator all hold.
- R6: The valid flag is low from reset until STAGES+1 enabled edges have passed. It is high after that.
- R7: A synchronous active-high reset clears the rotated outputs, the residual, the valid flag and the accumulator.
- R8: Whenever the valid flag is high, the residual angle output, read as signed, lies within ±(2·round(2^ZW·atan(2^(1−STAGES))/2π) + STAGES + 2).
- R9: No internal adder overflows for any input whose magnitude sqrt(I²+Q²) is at most 39000 (with DW = 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_en | input | 1 | Accept a sample and advance the pipeline |
| i_i | input | DW | In-phase sample, signed |
| i_q | input | DW | Quadrature sample, signed |
| i_phase_inc | input | PW | Added to the accumulator on each enabled clock |
| i_phase_ofs | input | PW | Static offset added to the accumulator |
| o_i | output | DW+1 | Rotated in-phase value, scaled by K |
| o_q | output | DW+1 | Rotated quadrature value, scaled by K |
| o_resid | output | ZW | Residual angle left after the last stage, signed |
| o_valid | output | 1 | Output holds a real rotated sample |

## Verification
The rotation is driven with a fixed offset at each quarter-turn angle and just below each boundary, using on-axis, diagonal and most-negative inputs. These cases separate a wrong quadrant swap or sign from an iteration fault. Random samples under a new random offset on every clock test that the angle is taken per sample and not per block. A constant phasor under positive and negative increments tests accumulator order, wrap-around and the one-sample offset between accumulator and angle. Random enable gaps, filled with random data, and a reset in mid-stream separate proper stalling from dropped or doubled samples, and show whether the accumulator restarts from zero.

// File: rtl/rot_pkg.sv
package rot_pkg;

  localparam real PI = 3.14159265358979323846;

  // Arctangent of 2^-idx, in angle units where a full turn is 2^zw.
  function automatic int atan_units(input int idx, input int zw);
    real r;
    r = $atan(1.0 / (2.0 ** idx));
    return $rtoi(r / (2.0 * PI) * (2.0 ** zw) + 0.5);
  endfunction

endpackage

// File: rtl/rot_phase_gen.sv
module rot_phase_gen #(
  parameter int PW = 32,
  parameter int ZW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] inc,
  input  logic [PW-1:0] ofs,
  output logic [ZW-1:0] angle
);

  logic [PW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_q + inc;
  end

  // Offset joins before truncation so carries from low bits count.
  assign angle = ZW'((acc_q + ofs) >> (PW - ZW));

  // R5: a stalled clock leaves the accumulator alone
  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/rot_prerot.sv
module rot_prerot #(
  parameter int DW = 16,
  parameter int FB = 6,
  parameter int ZW = 24,
  localparam int IW = DW + 1 + FB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  input  logic        [ZW-1:0] ang,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 v_o
);

  localparam logic signed [ZW-1:0] QTR = {2'b01, {(ZW-2){1'b0}}};

  logic signed [IW-1:0] xe, ye, x_n, y_n;
  logic signed [ZW-1:0] z_n;

  always_comb begin
    xe = {i_in[DW-1], i_in, {FB{1'b0}}};
    ye = {q_in[DW-1], q_in, {FB{1'b0}}};
    case (ang[ZW-1 -: 2])
      2'b01: begin
        x_n = -ye;
        y_n = xe;
        z_n = $signed(ang) - QTR;
      end
      2'b10: begin
        x_n = ye;
        y_n = -xe;
        z_n = $signed(ang) + QTR;
      end
      default: begin
        x_n = xe;
        y_n = ye;
        z_n = $signed(ang);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
      v_o <= 1'b0;
    end else if (en) begin
      x_o <= x_n;
      y_o <= y_n;
      z_o <= z_n;
      v_o <= 1'b1;
    end
  end

  // R3: residual after quadrant folding stays within a quarter turn
  assert_prerot_range_R3: assert property (@(posedge clk) disable iff (rst)
    z_o[ZW-1] == z_o[ZW-2]);

endmodule

// File: rtl/rot_cordic_stage.sv
module rot_cordic_stage #(
  parameter int IW  = 23,
  parameter int ZW  = 24,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic                 v_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 v_o
);

  localparam logic signed [ZW-1:0] ANG = ZW'(rot_pkg::atan_units(IDX, ZW));

  logic                 pos;
  logic signed [IW-1:0] dx, dy, x_n, y_n;
  logic signed [ZW-1:0] z_n;

  always_comb begin
    pos = ~z_i[ZW-1];
    dx  = pos ? -(y_i >>> IDX) : (y_i >>> IDX);
    dy  = pos ? (x_i >>> IDX) : -(x_i >>> IDX);
    x_n = x_i + dx;
    y_n = y_i + dy;
    z_n = pos ? (z_i - ANG) : (z_i + ANG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
      v_o <= 1'b0;
    end else if (en) begin
      x_o <= x_n;
      y_o <= y_n;
      z_o <= z_n;
      v_o <= v_i;
    end
  end

  // R9: same-sign operands never yield a result of the other sign
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    en |-> !((x_i[IW-1] == dx[IW-1]) && (x_n[IW-1] != x_i[IW-1])) &&
           !((y_i[IW-1] == dy[IW-1]) && (y_n[IW-1] != y_i[IW-1])));

endmodule

// File: rtl/iq_phase_rotator.sv
module iq_phase_rotator #(
  parameter int DW     = 16,
  parameter int PW     = 32,
  parameter int ZW     = 24,
  parameter int STAGES = 20,
  parameter int FB     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_en,
  input  logic signed [DW-1:0] i_i,
  input  logic signed [DW-1:0] i_q,
  input  logic        [PW-1:0] i_phase_inc,
  input  logic        [PW-1:0] i_phase_ofs,
  output logic signed [DW:0]   o_i,
  output logic signed [DW:0]   o_q,
  output logic signed [ZW-1:0] o_resid,
  output logic                 o_valid
);

  localparam int IW = DW + 1 + FB;
  localparam int OW = DW + 1;
  localparam int RES_BOUND = 2 * rot_pkg::atan_units(STAGES - 1, ZW) + STAGES + 2;

  logic        [ZW-1:0] angle;
  logic signed [IW-1:0] xs [STAGES+1];
  logic signed [IW-1:0] ys [STAGES+1];
  logic signed [ZW-1:0] zs [STAGES+1];
  logic                 vs [STAGES+1];

  rot_phase_gen #(.PW(PW), .ZW(ZW)) u_phase (
    .clk(clk), .rst(rst), .en(i_en),
    .inc(i_phase_inc), .ofs(i_phase_ofs), .angle(angle)
  );

  rot_prerot #(.DW(DW), .FB(FB), .ZW(ZW)) u_pre (
    .clk(clk), .rst(rst), .en(i_en),
    .i_in(i_i), .q_in(i_q), .ang(angle),
    .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0]), .v_o(vs[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    rot_cordic_stage #(.IW(IW), .ZW(ZW), .IDX(g)) u_st (
      .clk(clk), .rst(rst), .en(i_en),
      .x_i(xs[g]),   .y_i(ys[g]),   .z_i(zs[g]),   .v_i(vs[g]),
      .x_o(xs[g+1]), .y_o(ys[g+1]), .z_o(zs[g+1]), .v_o(vs[g+1])
    );
  end

  // Drop the fraction bits: floor to the output grid.
  assign o_i     = OW'(xs[STAGES] >>> FB);
  assign o_q     = OW'(ys[STAGES] >>> FB);
  assign o_resid = zs[STAGES];
  assign o_valid = vs[STAGES];

  // R5: stalled clock keeps every output
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !i_en |=> ($stable(o_i) && $stable(o_q) && $stable(o_resid) && $stable(o_valid)));

  // R7: reset leaves outputs cleared
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!o_valid && (o_i == '0) && (o_q == '0) && (o_resid == '0)));

  // R8: iterations converge on a near-zero residual
  assert_residual_R8: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (($signed(o_resid) <= RES_BOUND) && ($signed(o_resid) >= -RES_BOUND)));

endmodule

// File: tb/sim_iq_phase_rotator.sv
module sim_iq_phase_rotator;

  localparam int  DW  = 16;
  localparam int  PW  = 32;
  localparam int  ZW  = 24;
  localparam int  N   = 20;
  localparam int  SEG = 4096;
  localparam real TOL = 3.0;
  localparam real PI  = 3.14159265358979323846;
  // 2*atan(2^-19) in 2^24-per-turn units (5) plus N plus 2
  localparam int  RBOUND = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst = 1'b1;
  logic                 i_en = 1'b0;
  logic signed [DW-1:0] i_i = '0;
  logic signed [DW-1:0] i_q = '0;
  logic        [PW-1:0] i_phase_inc = '0;
  logic        [PW-1:0] i_phase_ofs = '0;
  logic signed [DW:0]   o_i, o_q;
  logic signed [ZW-1:0] o_resid;
  logic                 o_valid;

  iq_phase_rotator #(.DW(DW), .PW(PW), .ZW(ZW), .STAGES(N)) u0 (
    .clk(clk), .rst(rst), .i_en(i_en), .i_i(i_i), .i_q(i_q),
    .i_phase_inc(i_phase_inc), .i_phase_ofs(i_phase_ofs),
    .o_i(o_i), .o_q(o_q), .o_resid(o_resid), .o_valid(o_valid)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  real kgain;

  logic        [PW-1:0] acc_m;
  int                   nsamp;
  logic signed [DW-1:0] mi [SEG];
  logic signed [DW-1:0] mq [SEG];
  logic        [ZW-1:0] ma [SEG];

  function automatic logic signed [DW-1:0] rnd_s(input int lim);
    int v;
    v = int'($urandom_range(2 * lim)) - lim;
    return DW'(v);
  endfunction

  task automatic check_rot(input int s, input string tag);
    real th, xr, yr, ex, ey;
    th = real'(ma[s]) * 2.0 * PI / (2.0 ** ZW);
    xr = kgain * (real'(mi[s]) * $cos(th) - real'(mq[s]) * $sin(th));
    yr = kgain * (real'(mi[s]) * $sin(th) + real'(mq[s]) * $cos(th));
    ex = real'(o_i) - xr;
    ey = real'(o_q) - yr;
    checks++;
    if (ex > TOL || ex < -TOL || ey > TOL || ey < -TOL) begin
      fails++;
      $display("FAIL %s sample %0d: got (%0d,%0d) expected (%0.2f,%0.2f)",
               tag, s, o_i, o_q, xr, yr);
    end
    checks++;
    if ($signed(o_resid) > RBOUND || $signed(o_resid) < -RBOUND) begin
      fails++;
      $display("FAIL R8 sample %0d: residual %0d expected within +/-%0d",
               s, o_resid, RBOUND);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks after it.
  task automatic step(input bit en, input logic signed [DW-1:0] si,
                      input logic signed [DW-1:0] sq, input logic [PW-1:0] inc,
                      input logic [PW-1:0] ofs, input string tag);
    logic signed [DW:0]   p_i, p_q;
    logic signed [ZW-1:0] p_r;
    logic                 p_v;
    i_en = en; i_i = si; i_q = sq; i_phase_inc = inc; i_phase_ofs = ofs;
    if (en) begin
      mi[nsamp] = si;
      mq[nsamp] = sq;
      ma[nsamp] = ZW'((acc_m + ofs) >> (PW - ZW));  // R2 angle code
      acc_m = acc_m + inc;
      nsamp++;
    end
    p_i = o_i; p_q = o_q; p_r = o_resid; p_v = o_valid;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      checks++;
      if (nsamp >= N + 1) begin
        if (o_valid !== 1'b1) begin
          fails++;
          $display("FAIL R6 valid after %0d enabled edges: got %b expected 1", nsamp, o_valid);
        end
        // R4: the sample N+1 enabled edges back is now at the output
        check_rot(nsamp - N - 1, tag);
      end else if (o_valid !== 1'b0) begin
        fails++;
        $display("FAIL R6 valid after %0d enabled edges: got %b expected 0", nsamp, o_valid);
      end
    end else begin
      checks++;
      if (o_i !== p_i || o_q !== p_q || o_resid !== p_r || o_valid !== p_v) begin
        fails++;
        $display("FAIL R5 hold: got (%0d,%0d,%0d,%b) expected (%0d,%0d,%0d,%b)",
                 o_i, o_q, o_resid, o_valid, p_i, p_q, p_r, p_v);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    i_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (o_valid !== 1'b0 || o_i !== '0 || o_q !== '0 || o_resid !== '0) begin
      fails++;
      $display("FAIL R7 reset state: got (%0d,%0d,%0d,%b) expected (0,0,0,0)",
               o_i, o_q, o_resid, o_valid);
    end
    rst = 1'b0;
    acc_m = '0;
    nsamp = 0;
  endtask

  localparam logic [PW-1:0] DIR_ANG [8] = '{
    32'h0000_0000, 32'h4000_0000, 32'h8000_0000, 32'hC000_0000,
    32'h3FFF_FF00, 32'h7FFF_FFFF, 32'hBFFF_FFFF, 32'hFFFF_FF00 };
  localparam logic signed [DW-1:0] DIR_I [5] = '{ 16'sd30000, 16'sd0, -16'sd21000, -16'sd32768, 16'sd21000 };
  localparam logic signed [DW-1:0] DIR_Q [5] = '{ 16'sd0, 16'sd30000, 16'sd21000, 16'sd0, -16'sd21000 };

  initial begin
    void'($urandom(32'd7351));
    kgain = 1.0;
    for (int i = 0; i < N; i++) kgain = kgain * $sqrt(1.0 + 2.0 ** (-2 * i));

    do_reset();  // R7, R6

    // R3: quarter-turn angles and codes just under the boundaries
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 5; s++)
        step(1'b1, DIR_I[s], DIR_Q[s], '0, DIR_ANG[a], "R3");

    // R9: largest allowed magnitude on the diagonals
    step(1'b1,  16'sd27000,  16'sd27000, '0, 32'h1234_5678, "R9");
    step(1'b1, -16'sd27000,  16'sd27000, '0, 32'h5A5A_0000, "R9");
    step(1'b1, -16'sd27000, -16'sd27000, '0, 32'hA000_0001, "R9");
    step(1'b1,  16'sd27000, -16'sd27000, '0, 32'hE111_1111, "R9");

    // R1: random samples, new random angle every clock
    for (int k = 0; k < 400; k++)
      step(1'b1, rnd_s(21000), rnd_s(21000), '0, $urandom, "R1");

    // R2: frequency tuning from a fresh accumulator
    do_reset();
    for (int k = 0; k < 300; k++)
      step(1'b1, 16'sd25000, 16'sd0, 32'h0123_4567, 32'h3000_0000, "R2");
    for (int k = 0; k < 300; k++)
      step(1'b1, rnd_s(21000), rnd_s(21000), 32'hFEDC_1234, 32'h3000_0000, "R2");

    // R5: random stalls with random data present on the inputs
    for (int k = 0; k < 800; k++)
      step($urandom_range(3) != 0, rnd_s(21000), rnd_s(21000),
           32'h0071_C000, 32'h0BAD_F00D, "R5");

    // R7: reset in mid-stream, then the accumulator restarts at zero
    do_reset();
    for (int k = 0; k < 120; k++)
      step(1'b1, rnd_s(21000), rnd_s(21000), 32'h2000_0003, 32'h0000_0000, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog: run still busy at 200000 cycles, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule